// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Snapshot and Staged Load

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of month, month and two-digit year. It advances from a slow tick input. A parameter sets how many ticks make one second. Software reaches the block through a plain register read/write port. The time values that software sees are a separate user image, not the running counters. Software raises a capture bit to copy the counters into that image as one consistent set. It sets a freeze bit to edit the image, and the release of freeze loads the edited image into the counters.

An alarm comparator checks up to five fields (seconds through month) against alarm registers. Each field has its own skip bit. A match raises a sticky alarm flag that only software clears, and an active-low alarm pin follows that flag. A second sticky flag records the year wrapping from 99 to 00. A halt bit stops timekeeping and is set on reset. A six-bit calibration register is only stored: it takes writes only while calibration mode is on, and calibration mode also keeps the alarm pin inactive.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset all counters, user time registers, alarm registers, the calibration register and both flags are 0, and the control register (address 0) reads 0x80. Control bit layout: [0] capture, [1] freeze, [2] calibration mode, [3] alarm enable, [4] alarm flag, [5] century flag, [6] reads 0, [7] halt. Addresses 13 and up read 0.
- R2: While running, the seconds counter advances once every TICKS_PER_SEC ticks. Seconds and minutes count 00–59 and hours count 00–23, in packed BCD, and each carries into the next field.
- R3: The day of month rolls to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, and 31 for the other months except 02. February has 29 days when the BCD year is divisible by 4 and 28 otherwise. Month 12 rolls to 01 and carries into the year.
- R4: The century flag (bit 5) is set when the year rolls from 99 to 00. Writing 0 to bit 5 clears it, and writing 1 leaves it as it is.
- R5: While halt (bit 7) is 1, ticks are ignored and the counters hold.
- R6: A control write that changes the capture bit from 0 to 1, with freeze 0 before and after the write, copies all six counters into the user time registers (addresses 2–7: seconds, minutes, hours, date, month, year). Writing 1 again without first writing 0 captures nothing.
- R7: Writes to the user time registers are accepted only while freeze is 1 and are ignored otherwise. While freeze is 1, nothing but such writes changes them.
- R8: A control write that changes freeze from 1 to 0 loads the user time registers into the counters and restarts the tick sub-count, so the next second ends a full TICKS_PER_SEC ticks later.
- R9: The alarm registers at addresses 8–12 cover seconds, minutes, hours, date and month. In each one, bit 7 = 1 skips the field and bits [6:0] hold the BCD value to compare. When a second advance produces a time that matches every compared field while alarm enable is 1, the alarm flag (bit 4) is set. The flag stays set until a control write puts 0 in bit 4.
- R10: While alarm enable is 0, no new alarm sets the flag. Clearing alarm enable does not clear a flag that is already set.
- R11: alarm_n is low exactly when the alarm flag is 1, alarm enable is 1 and calibration mode is 0.
- R12: The calibration register at address 1 holds a code in bits [4:0] and a sign in bit 5, and its bits 7:6 read 0. Writes to it take effect only while calibration mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | Timebase tick, one clock wide per pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| alarm_n | output | 1 | Active-low alarm indication |

## Verification
The bench builds the core with TICKS_PER_SEC set to 2, leap years enabled and all five alarm fields. With two ticks per second, a load can land in the middle of a second, so the restart of the sub-count after a transfer shows up as a tick that does not advance the time. The bench preloads times such as 23:59:58 on 28 February and 23:59:59 on 31 December of year 99. Minute, hour, day, month, year and century carries then follow within a few ticks, in both leap and non-leap years.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NUM_TIME  = 6;
   localparam int NUM_ALARM = 5;
   localparam int BCD_W     = 8;

   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DATE = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [NUM_TIME-1:0][BCD_W-1:0] time_vec_t;

   // add one to a packed two-digit BCD value (no upper limit handling)
   function automatic bcd_t bcd_inc(input bcd_t v);
      bcd_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // (10*t + o) mod 4 == (2*t + o) mod 4; only the low two bits matter
   function automatic logic yr_div4(input bcd_t yr);
      logic [4:0] s;
      s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr, input logic leap_on);
      bcd_t d;
      case (mon)
         8'h02:                      d = (leap_on && yr_div4(yr)) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
         default:                    d = 8'h31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
   parameter int TICKS_PER_SEC = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   output logic sec_step
);

   localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

   if (TICKS_PER_SEC < 1) begin : g_bad_tps
      $error("rtc_prescale: TICKS_PER_SEC must be at least 1");
   end

   if (TICKS_PER_SEC == 1) begin : g_direct
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign sec_step   = tick_en & ~restart;
   end else begin : g_div
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
      logic [CW-1:0] sub_cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || restart) begin
            sub_cnt <= '0;
         end else if (tick_en) begin
            if (sub_cnt == LAST) sub_cnt <= '0;
            else                 sub_cnt <= sub_cnt + CW'(1);
         end
      end

      assign sec_step = tick_en & ~restart & (sub_cnt == LAST);
   end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  time_vec_t load_val,
   output time_vec_t cur,
   output time_vec_t nxt,
   output logic      year_wrap
);

   bcd_t month_end;

   assign month_end = last_day(cur[F_MON], cur[F_YEAR], LEAP_EN);

   // next value of the whole chain; out-of-range fields fall back to their first value
   always_comb begin
      nxt       = cur;
      year_wrap = 1'b0;
      if (cur[F_SEC] >= 8'h59) begin
         nxt[F_SEC] = 8'h00;
         if (cur[F_MIN] >= 8'h59) begin
            nxt[F_MIN] = 8'h00;
            if (cur[F_HOUR] >= 8'h23) begin
               nxt[F_HOUR] = 8'h00;
               if (cur[F_DATE] >= month_end) begin
                  nxt[F_DATE] = 8'h01;
                  if (cur[F_MON] >= 8'h12) begin
                     nxt[F_MON] = 8'h01;
                     if (cur[F_YEAR] >= 8'h99) begin
                        nxt[F_YEAR] = 8'h00;
                        year_wrap   = 1'b1;
                     end else begin
                        nxt[F_YEAR] = bcd_inc(cur[F_YEAR]);
                     end
                  end else begin
                     nxt[F_MON] = bcd_inc(cur[F_MON]);
                  end
               end else begin
                  nxt[F_DATE] = bcd_inc(cur[F_DATE]);
               end
            end else begin
               nxt[F_HOUR] = bcd_inc(cur[F_HOUR]);
            end
         end else begin
            nxt[F_MIN] = bcd_inc(cur[F_MIN]);
         end
      end else begin
         nxt[F_SEC] = bcd_inc(cur[F_SEC]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cur <= '0;
      else if (load)  cur <= load_val;
      else if (step)  cur <= nxt;
   end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_pkg::*;
#(
   parameter int FIELDS = NUM_ALARM
)(
   input  time_vec_t                    probe,
   input  logic [FIELDS-1:0][BCD_W-1:0] alarm_regs,
   output logic                         hit
);

   if (FIELDS < 1 || FIELDS > NUM_TIME) begin : g_bad_fields
      $error("rtc_alarm_cmp: FIELDS out of range");
   end

   logic [FIELDS-1:0] field_ok;
   logic              unused_probe;

   for (genvar i = 0; i < FIELDS; i++) begin : g_fld
      assign field_ok[i] = alarm_regs[i][BCD_W-1] |
                           (alarm_regs[i][BCD_W-2:0] == probe[i][BCD_W-2:0]);
   end

   assign unused_probe = ^probe;
   assign hit          = &field_ok;

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int TICKS_PER_SEC = 1,
   parameter bit LEAP_EN       = 1'b1,
   parameter int ALARM_FIELDS  = NUM_ALARM
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              alarm_n
);

   localparam int A_CTRL  = 0;
   localparam int A_CAL   = 1;
   localparam int A_TIME  = 2;
   localparam int A_ALARM = A_TIME + NUM_TIME;
   localparam int A_END   = A_ALARM + ALARM_FIELDS;
   localparam int CAL_W   = 6;

   localparam int CB_SNAP = 0;
   localparam int CB_FRZ  = 1;
   localparam int CB_CAL  = 2;
   localparam int CB_AEN  = 3;
   localparam int CB_AF   = 4;
   localparam int CB_CF   = 5;
   localparam int CB_HALT = 7;

   if (A_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("bcd_rtc_core: ADDR_W too small for the register map");
   end
   if (ALARM_FIELDS < 1 || ALARM_FIELDS > NUM_TIME) begin : g_bad_alarm
      $error("bcd_rtc_core: ALARM_FIELDS out of range");
   end

   logic snap_q, freeze_q, cal_mode_q, alarm_en_q, halt_q;
   logic alarm_flag_q, century_q;
   logic [CAL_W-1:0] cal_q;
   time_vec_t user_q;
   logic [ALARM_FIELDS-1:0][BCD_W-1:0] alarm_q;

   logic wr_ctrl, xfer, capture, tick_en, sec_step;
   logic alarm_hit, year_wrap, alarm_set, cent_set;
   time_vec_t cur_t, nxt_t;

   assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));
   assign xfer    = wr_ctrl && freeze_q && !reg_wdata[CB_FRZ];
   assign capture = wr_ctrl && !snap_q && reg_wdata[CB_SNAP] &&
                    !freeze_q && !reg_wdata[CB_FRZ];
   assign tick_en = tick_1hz && !halt_q;

   rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .restart  (xfer),
      .sec_step (sec_step)
   );

   rtc_time_chain #(.LEAP_EN(LEAP_EN)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (sec_step),
      .load      (xfer),
      .load_val  (user_q),
      .cur       (cur_t),
      .nxt       (nxt_t),
      .year_wrap (year_wrap)
   );

   rtc_alarm_cmp #(.FIELDS(ALARM_FIELDS)) u_alarm (
      .probe      (nxt_t),
      .alarm_regs (alarm_q),
      .hit        (alarm_hit)
   );

   assign alarm_set = sec_step && alarm_en_q && alarm_hit;
   assign cent_set  = sec_step && year_wrap;

   // control and sticky flags; a set event wins over a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q       <= 1'b0;
         freeze_q     <= 1'b0;
         cal_mode_q   <= 1'b0;
         alarm_en_q   <= 1'b0;
         halt_q       <= 1'b1;
         alarm_flag_q <= 1'b0;
         century_q    <= 1'b0;
      end else if (wr_ctrl) begin
         snap_q       <= reg_wdata[CB_SNAP];
         freeze_q     <= reg_wdata[CB_FRZ];
         cal_mode_q   <= reg_wdata[CB_CAL];
         alarm_en_q   <= reg_wdata[CB_AEN];
         halt_q       <= reg_wdata[CB_HALT];
         alarm_flag_q <= alarm_set | (alarm_flag_q & reg_wdata[CB_AF]);
         century_q    <= cent_set  | (century_q    & reg_wdata[CB_CF]);
      end else begin
         alarm_flag_q <= alarm_flag_q | alarm_set;
         century_q    <= century_q    | cent_set;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_q <= '0;
      end else if (reg_we && (reg_addr == ADDR_W'(A_CAL)) && cal_mode_q) begin
         cal_q <= reg_wdata[CAL_W-1:0];
      end
   end

   // user time image: capture when not frozen, bus writes only when frozen
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         user_q <= '0;
      end else if (capture) begin
         user_q <= cur_t;
      end else if (reg_we && freeze_q) begin
         for (int i = 0; i < NUM_TIME; i++) begin
            if (reg_addr == ADDR_W'(A_TIME + i)) user_q[i] <= reg_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '0;
      end else if (reg_we) begin
         for (int i = 0; i < ALARM_FIELDS; i++) begin
            if (reg_addr == ADDR_W'(A_ALARM + i)) alarm_q[i] <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CTRL)) begin
         reg_rdata = {halt_q, 1'b0, century_q, alarm_flag_q,
                      alarm_en_q, cal_mode_q, freeze_q, snap_q};
      end
      if (reg_addr == ADDR_W'(A_CAL)) reg_rdata = {{(8-CAL_W){1'b0}}, cal_q};
      for (int i = 0; i < NUM_TIME; i++) begin
         if (reg_addr == ADDR_W'(A_TIME + i)) reg_rdata = user_q[i];
      end
      for (int i = 0; i < ALARM_FIELDS; i++) begin
         if (reg_addr == ADDR_W'(A_ALARM + i)) reg_rdata = alarm_q[i];
      end
   end

   assign alarm_n = ~(alarm_flag_q & alarm_en_q & ~cal_mode_q);

endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              alarm_n,
   input logic              halt,
   input logic              load,
   input logic              step,
   input time_vec_t         cur,
   input time_vec_t         user,
   input logic              freeze,
   input logic              cal_mode,
   input logic [5:0]        cal_reg,
   input logic              alarm_en,
   input logic              alarm_flag,
   input logic              century
);

   logic ctrl_wr, flag_clear, time_wr, unused_wd;

   assign ctrl_wr    = reg_we && (reg_addr == '0);
   assign flag_clear = ctrl_wr && !reg_wdata[4];
   assign time_wr    = reg_we && (reg_addr >= ADDR_W'(2)) && (reg_addr <= ADDR_W'(7));
   assign unused_wd  = ^reg_wdata;

   // R5: halted counters hold unless a transfer loads them
   a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !load) |=> $stable(cur));

   // R2: an advanced seconds value is valid packed BCD
   a_r2_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cur[F_SEC][3:0] <= 4'd9 && cur[F_SEC] <= 8'h59));

   // R4: leaving year 99 for 00 leaves the century flag set
   a_r4_century_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cur[F_YEAR] == 8'h99 && !load) |=> (cur[F_YEAR] != 8'h00 || century));

   // R7: the frozen user image changes only through bus writes
   a_r7_frozen_user_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !time_wr) |=> $stable(user));

   // R9: the alarm flag stays set until a clearing write
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !flag_clear) |=> alarm_flag);

   // R10: no new alarm while the enable is low
   a_r10_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_en && !alarm_flag) |=> !alarm_flag);

   // R11: calibration mode keeps the alarm pin inactive
   a_r11_quiet_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
      cal_mode |-> alarm_n);

   // R12: calibration contents locked outside calibration mode
   a_r12_cal_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_mode |=> $stable(cal_reg));

endmodule

bind bcd_rtc_core rtc_core_checker #(.ADDR_W(ADDR_W)) u_rtc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .alarm_n    (alarm_n),
   .halt       (halt_q),
   .load       (xfer),
   .step       (sec_step),
   .cur        (cur_t),
   .user       (user_q),
   .freeze     (freeze_q),
   .cal_mode   (cal_mode_q),
   .cal_reg    (cal_q),
   .alarm_en   (alarm_en_q),
   .alarm_flag (alarm_flag_q),
   .century    (century_q)
);

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;

   localparam int TPS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       we = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       alarm_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bcd_rtc_core #(.ADDR_W(4), .TICKS_PER_SEC(TPS), .LEAP_EN(1'b1), .ALARM_FIELDS(5)) uut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .reg_we(we),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .alarm_n(alarm_n)
   );

   // ---------------- reference model ----------------
   int m_t[6];      // counters, binary
   int m_user[6];   // user image, BCD bytes
   int m_alm[5];
   int m_sub, m_calr;
   bit m_snap, m_frz, m_cal, m_aen, m_af, m_cf, m_halt;

   function automatic int to_bcd(input int v);
      return (v / 10) * 16 + (v % 10);
   endfunction
   function automatic int from_bcd(input int b);
      return (b / 16) * 10 + (b % 16);
   endfunction
   function automatic int days_of(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   always @(posedge clk) begin : model
      int  old[6];
      bit  step, load, cap, cfe, ae, hit;
      int  a;
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) begin m_t[i] = 0; m_user[i] = 0; end
         for (int i = 0; i < 5; i++) m_alm[i] = 0;
         m_sub = 0; m_calr = 0;
         m_snap = 0; m_frz = 0; m_cal = 0; m_aen = 0; m_af = 0; m_cf = 0; m_halt = 1;
      end else begin
         a = int'(addr);
         for (int i = 0; i < 6; i++) old[i] = m_t[i];
         load = we && a == 0 && m_frz && !wdata[1];
         cap  = we && a == 0 && !m_snap && wdata[0] && !m_frz && !wdata[1];
         step = 0; cfe = 0; ae = 0;
         if (load) begin
            for (int i = 0; i < 6; i++) m_t[i] = from_bcd(m_user[i]);
            m_sub = 0;
         end else if (tick && !m_halt) begin
            if (m_sub == TPS - 1) begin m_sub = 0; step = 1; end
            else m_sub = m_sub + 1;
         end
         if (step) begin
            m_t[0]++;
            if (m_t[0] > 59) begin m_t[0] = 0; m_t[1]++;
               if (m_t[1] > 59) begin m_t[1] = 0; m_t[2]++;
                  if (m_t[2] > 23) begin m_t[2] = 0; m_t[3]++;
                     if (m_t[3] > days_of(m_t[4], m_t[5])) begin m_t[3] = 1; m_t[4]++;
                        if (m_t[4] > 12) begin m_t[4] = 1; m_t[5]++;
                           if (m_t[5] > 99) begin m_t[5] = 0; cfe = 1; end
                        end
                     end
                  end
               end
            end
            hit = 1;
            for (int i = 0; i < 5; i++)
               if ((m_alm[i] & 128) == 0 && (m_alm[i] & 127) != to_bcd(m_t[i])) hit = 0;
            ae = hit && m_aen;
         end
         if (we && a == 1 && m_cal) m_calr = int'(wdata) & 63;
         if (we && a >= 2 && a <= 7 && m_frz) m_user[a-2] = int'(wdata);
         if (we && a >= 8 && a <= 12) m_alm[a-8] = int'(wdata);
         if (cap) for (int i = 0; i < 6; i++) m_user[i] = to_bcd(old[i]);
         if (we && a == 0) begin
            m_snap = wdata[0]; m_frz = wdata[1]; m_cal = wdata[2];
            m_aen = wdata[3]; m_halt = wdata[7];
            m_af = ae  | (m_af & wdata[4]);
            m_cf = cfe | (m_cf & wdata[5]);
         end else begin
            m_af = m_af | ae;
            m_cf = m_cf | cfe;
         end
      end
   end

   function automatic logic [7:0] exp_rd(input int a);
      if (a == 0) return {m_halt, 1'b0, m_cf, m_af, m_aen, m_cal, m_frz, m_snap};
      if (a == 1) return 8'(m_calr);
      if (a >= 2 && a <= 7) return 8'(m_user[a-2]);
      if (a >= 8 && a <= 12) return 8'(m_alm[a-8]);
      return 8'h00;
   endfunction

   function automatic string tag_of(input int a);
      if (a == 0) return "R4";
      if (a == 1) return "R12";
      if (a >= 2 && a <= 7) return "R7";
      if (a >= 8 && a <= 12) return "R9";
      return "R1";
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, after the model has updated
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(tag_of(int'(addr)), rdata, exp_rd(int'(addr)));
         chk("R11", {7'd0, alarm_n}, {7'd0, !(m_af && m_aen && !m_cal)});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input int d);
      @(negedge clk); we = 1'b1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk); we = 1'b0;
   endtask

   task automatic pulse(input int n);
      repeat (n) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic rd_chk(input string tag, input int a, input int exp);
      @(negedge clk); addr = 4'(a); #1;
      chk(tag, rdata, 8'(exp));
   endtask

   task automatic pin_chk(input string tag, input bit exp);
      @(negedge clk); #1;
      chk(tag, {7'd0, alarm_n}, {7'd0, exp});
   endtask

   task automatic snapshot(input int base);
      wr(0, base | 1);
      wr(0, base);
   endtask

   task automatic preload(input int s, input int mi, input int h, input int d,
                          input int mo, input int y);
      wr(0, 8'h32);
      wr(2, s); wr(3, mi); wr(4, h); wr(5, d); wr(6, mo); wr(7, y);
      wr(0, 8'h30);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_chk("R1", 0, 8'h80);
      rd_chk("R1", 1, 8'h00);
      rd_chk("R1", 2, 8'h00);
      rd_chk("R1", 7, 8'h00);
      rd_chk("R1", 8, 8'h00);
      rd_chk("R1", 14, 8'h00);

      // R2: run, 6 ticks = 3 seconds at two ticks per second
      wr(0, 8'h30);
      pulse(6);
      snapshot(8'h30);
      rd_chk("R2", 2, 8'h03);

      // R6: second capture without returning the bit to 0 does nothing
      wr(0, 8'h31);
      pulse(4);
      wr(0, 8'h31);
      rd_chk("R6", 2, 8'h03);
      wr(0, 8'h30);
      wr(0, 8'h31);
      rd_chk("R6", 2, 8'h05);
      wr(0, 8'h30);

      // R5: halted, ticks ignored
      wr(0, 8'hB0);
      pulse(6);
      snapshot(8'hB0);
      rd_chk("R5", 2, 8'h05);
      wr(0, 8'h30);

      // R7: time writes ignored while not frozen
      wr(2, 8'h42);
      rd_chk("R7", 2, 8'h05);

      // R8 and R3: load mid-second, leap February
      pulse(1);
      wr(0, 8'h32);
      wr(2, 8'h58); wr(3, 8'h59); wr(4, 8'h23); wr(5, 8'h28); wr(6, 8'h02); wr(7, 8'h24);
      rd_chk("R7", 4, 8'h23);
      wr(0, 8'h30);
      pulse(1);
      snapshot(8'h30);
      rd_chk("R8", 2, 8'h58);
      pulse(1);
      snapshot(8'h30);
      rd_chk("R8", 2, 8'h59);
      pulse(2);
      snapshot(8'h30);
      rd_chk("R2", 2, 8'h00);
      rd_chk("R2", 3, 8'h00);
      rd_chk("R2", 4, 8'h00);
      rd_chk("R3", 5, 8'h29);
      rd_chk("R3", 6, 8'h02);

      // R3: non-leap February ends on 28
      preload(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
      pulse(2);
      snapshot(8'h30);
      rd_chk("R3", 5, 8'h01);
      rd_chk("R3", 6, 8'h03);

      // R3: 30-day month
      preload(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23);
      pulse(2);
      snapshot(8'h30);
      rd_chk("R3", 5, 8'h01);
      rd_chk("R3", 6, 8'h05);

      // R4: century wrap
      preload(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
      pulse(2);
      snapshot(8'h30);
      rd_chk("R4", 7, 8'h00);
      rd_chk("R3", 6, 8'h01);
      rd_chk("R3", 5, 8'h01);
      rd_chk("R4", 0, 8'h20);
      wr(0, 8'h30);
      rd_chk("R4", 0, 8'h20);
      wr(0, 8'h10);
      rd_chk("R4", 0, 8'h00);

      // R9: seconds-only alarm at 03
      wr(8, 8'h03);
      wr(9, 8'h80); wr(10, 8'h80); wr(11, 8'h80); wr(12, 8'h80);
      wr(0, 8'h38);
      pulse(6);
      rd_chk("R9", 0, 8'h18);
      pin_chk("R11", 1'b0);
      wr(0, 8'h28);
      rd_chk("R9", 0, 8'h08);
      pin_chk("R11", 1'b1);

      // R10: disabled alarm does not set the flag
      wr(0, 8'h30);
      wr(8, 8'h05);
      pulse(4);
      rd_chk("R10", 0, 8'h00);

      // R10: clearing enable keeps a set flag
      wr(8, 8'h07);
      wr(0, 8'h38);
      pulse(4);
      rd_chk("R9", 0, 8'h18);
      wr(0, 8'h30);
      rd_chk("R10", 0, 8'h10);
      pin_chk("R11", 1'b1);

      // R9: minute field compared too, no match on minute 05
      wr(9, 8'h05);
      wr(8, 8'h09);
      wr(0, 8'h28);
      pulse(4);
      rd_chk("R9", 0, 8'h08);

      // R11: calibration mode hides the alarm
      wr(9, 8'h80);
      wr(8, 8'h11);
      pulse(4);
      rd_chk("R9", 0, 8'h18);
      wr(0, 8'h3C);
      pin_chk("R11", 1'b1);
      wr(0, 8'h38);
      pin_chk("R11", 1'b0);

      // R12: calibration register write lock
      wr(1, 8'h25);
      rd_chk("R12", 1, 8'h00);
      wr(0, 8'h3C);
      wr(1, 8'h25);
      rd_chk("R12", 1, 8'h25);
      wr(1, 8'hFF);
      rd_chk("R12", 1, 8'h3F);
      wr(0, 8'h38);
      wr(1, 8'h00);
      rd_chk("R12", 1, 8'h3F);

      repeat (4) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule